// File: doc/BRIEF.md
# Scaler Mode and Setup Decoder

This block turns a scaler configuration into the settings the scaling pipeline runs with. The configuration is the pixel format class, four unsigned fixed-point scale ratios (horizontal and vertical, for the luma plane and for the chroma plane), a capability bit that says the datapath processes fixed-point data, a debug bit that forces scaling, four tap counts, and the geometry of the active area and the output rectangle. From these the block picks a 3-bit scaler mode through a fixed priority chain. It also produces the black-level offsets, the tap counts in their register form, and the overscan margins on all four sides.

The decode logic is combinational. Its results are captured into output registers only when a one-cycle load strobe is seen. If any tap count in the load is out of range, the load is refused: the outputs keep their previous values and an illegal-configuration flag is set. A ratio counts as unity only when it equals the exact 1.0 encoding, which is a one in bit FRAC_W and zeros in every other bit.

Top module: `scl_mode_decode`

## Requirements
- R1: When the fixed-format capability bit is set and the format class is half-float (code 3), the mode is 6, whatever the ratios. When the capability bit is clear, a half-float input goes through the rest of the chain as a non-video 4:4:4 format.
- R2: When all four ratios equal 1.0 and force-scale is clear, the mode is 0. When force-scale is set, unity ratios do not select mode 0.
- R3: When no earlier rule applies and the format is not 4:2:0, the mode is 2 for the YCbCr 4:4:4 class (code 1). For RGB (code 0) and half-float it is 1.
- R4: For the 4:2:0 class (code 2), when no earlier rule applies: unity luma ratios in both directions give mode 4. Otherwise, unity chroma ratios in both directions give mode 5. Otherwise the mode is 3. The luma test takes priority over the chroma test.
- R5: The luma/RGB black offset is always 0x0000. The chroma black offset is 0x8000 for the YCbCr classes (codes 1 and 2) and 0x0000 for the others.
- R6: Each tap code is the tap count minus one, in ENC_W bits. The fields are packed from the least significant end in this order: luma horizontal, luma vertical, chroma horizontal, chroma vertical.
- R7: The left margin equals the output x and the top margin equals the output y. The right margin is active width minus output x minus output width. The bottom margin is active height minus output y minus output height.
- R8: A right or bottom margin that would be negative is output as 0, and the margin error flag is set. The flag is clear when neither margin is negative.
- R9: The outputs change only in the cycle after an accepted load. The valid output pulses for exactly that one cycle. Without a load, the outputs hold.
- R10: A load in which any tap count is 0 or greater than MAX_TAPS sets the illegal flag and produces no valid pulse. All other outputs keep their previous values. The next legal load clears the flag.
- R11: After reset, the mode, offsets, tap codes, margins and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for the configuration |
| fmt_class | input | 2 | 0 RGB, 1 YCbCr 4:4:4, 2 YCbCr 4:2:0, 3 half-float |
| fixed_cap | input | 1 | The datapath processes fixed-point data |
| force_scale | input | 1 | Debug: never select the full 4:4:4 bypass |
| ratio_h_y | input | RATIO_W | Luma horizontal ratio |
| ratio_v_y | input | RATIO_W | Luma vertical ratio |
| ratio_h_c | input | RATIO_W | Chroma horizontal ratio |
| ratio_v_c | input | RATIO_W | Chroma vertical ratio |
| tap_h_y | input | TAP_W | Luma horizontal tap count |
| tap_v_y | input | TAP_W | Luma vertical tap count |
| tap_h_c | input | TAP_W | Chroma horizontal tap count |
| tap_v_c | input | TAP_W | Chroma vertical tap count |
| act_w | input | DIM_W | Active width |
| act_h | input | DIM_W | Active height |
| out_x | input | DIM_W | Output rectangle x origin |
| out_y | input | DIM_W | Output rectangle y origin |
| out_w | input | DIM_W | Output rectangle width |
| out_h | input | DIM_W | Output rectangle height |
| mode | output | 3 | Scaler mode code |
| blk_y | output | 16 | Luma/RGB black offset |
| blk_c | output | 16 | Chroma black offset |
| tap_code | output | 4*ENC_W | Packed tap codes |
| marg_l | output | DIM_W | Left margin |
| marg_r | output | DIM_W | Right margin |
| marg_t | output | DIM_W | Top margin |
| marg_b | output | DIM_W | Bottom margin |
| marg_err | output | 1 | A margin was clamped |
| cfg_illegal | output | 1 | The last load was refused |
| out_valid | output | 1 | One-cycle pulse after an accepted load |

## Verification
The hardest cases are the ones where two priority rules both match. Examples are a 4:2:0 load in which both the luma and chroma ratios are unity while force-scale is set, and a half-float load with unity ratios, run once with the capability bit set and once with it clear. The stimulus sets up each of these overlaps on purpose, so that the lower-priority mode would be the visible result if the chain were ordered wrongly. Refused loads are placed directly after a known legal load and carry different geometry and ratios, so any partial update would show at the ports.

// File: rtl/scl_setup_pkg.sv
package scl_setup_pkg;

  localparam int MODE_W = 3;
  localparam int BLK_W  = 16;

  typedef enum logic [MODE_W-1:0] {
    MODE_BYP444     = 3'd0,
    MODE_RGB444     = 3'd1,
    MODE_YUV444     = 3'd2,
    MODE_YUV420     = 3'd3,
    MODE_LUMA_BYP   = 3'd4,
    MODE_CHROMA_BYP = 3'd5,
    MODE_FULL_BYP   = 3'd6
  } scl_mode_e;

  typedef enum logic [1:0] {
    FMT_RGB    = 2'd0,
    FMT_YUV444 = 2'd1,
    FMT_YUV420 = 2'd2,
    FMT_FP16   = 2'd3
  } fmt_class_e;

  localparam logic [BLK_W-1:0] BLK_ZERO       = 16'h0000;
  localparam logic [BLK_W-1:0] BLK_CHROMA_MID = 16'h8000;

endpackage

// File: rtl/scl_mode_sel.sv
module scl_mode_sel
  import scl_setup_pkg::*;
#(
  parameter int RATIO_W = 24,
  parameter int FRAC_W  = 19
) (
  input  logic [1:0]                fmt_class,
  input  logic                      fixed_cap,
  input  logic                      force_scale,
  input  logic [3:0][RATIO_W-1:0]   ratios,
  output scl_mode_e                 mode,
  output logic                      is_video
);

  localparam logic [RATIO_W-1:0] UNITY =
    {{(RATIO_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  // ratio order: 0 luma h, 1 luma v, 2 chroma h, 3 chroma v
  logic [3:0] unity;

  for (genvar i = 0; i < 4; i++) begin : g_unity
    assign unity[i] = (ratios[i] == UNITY);
  end

  logic luma_unity, chroma_unity, fmt_420;

  assign luma_unity   = unity[0] & unity[1];
  assign chroma_unity = unity[2] & unity[3];
  assign fmt_420      = (fmt_class == FMT_YUV420);
  assign is_video     = (fmt_class == FMT_YUV444) || fmt_420;

  always_comb begin
    if (fixed_cap && fmt_class == FMT_FP16)
      mode = MODE_FULL_BYP;
    else if (luma_unity && chroma_unity && !force_scale)
      mode = MODE_BYP444;
    else if (!fmt_420)
      mode = is_video ? MODE_YUV444 : MODE_RGB444;
    else if (luma_unity)
      mode = MODE_LUMA_BYP;
    else if (chroma_unity)
      mode = MODE_CHROMA_BYP;
    else
      mode = MODE_YUV420;
  end

endmodule

// File: rtl/scl_tap_encode.sv
module scl_tap_encode #(
  parameter int TAP_W    = 4,
  parameter int MAX_TAPS = 8,
  parameter int NUM_FLD  = 4,
  parameter int ENC_W    = 3
) (
  input  logic [NUM_FLD-1:0][TAP_W-1:0] taps,
  output logic [NUM_FLD-1:0][ENC_W-1:0] enc,
  output logic                          legal
);

  localparam logic [TAP_W-1:0] LAST_CODE = TAP_W'(MAX_TAPS - 1);

  logic [NUM_FLD-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    logic [TAP_W-1:0] dec;
    assign dec       = taps[i] - TAP_W'(1);
    assign fld_ok[i] = (taps[i] != '0) && (dec <= LAST_CODE);
    assign enc[i]    = dec[ENC_W-1:0];
  end

  assign legal = &fld_ok;

endmodule

// File: rtl/scl_margin_calc.sv
module scl_margin_calc #(
  parameter int DIM_W = 14
) (
  input  logic [DIM_W-1:0] extent,
  input  logic [DIM_W-1:0] origin,
  input  logic [DIM_W-1:0] span,
  output logic [DIM_W-1:0] margin,
  output logic             clamped
);

  logic [DIM_W+1:0] diff;

  assign diff    = {2'b00, extent} - {2'b00, origin} - {2'b00, span};
  assign clamped = |diff[DIM_W+1:DIM_W];
  assign margin  = clamped ? '0 : diff[DIM_W-1:0];

endmodule

// File: rtl/scl_mode_decode.sv
module scl_mode_decode
  import scl_setup_pkg::*;
#(
  parameter int RATIO_W  = 24,
  parameter int FRAC_W   = 19,
  parameter int TAP_W    = 4,
  parameter int MAX_TAPS = 8,
  parameter int DIM_W    = 14,
  localparam int ENC_W   = $clog2(MAX_TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [1:0]           fmt_class,
  input  logic                 fixed_cap,
  input  logic                 force_scale,
  input  logic [RATIO_W-1:0]   ratio_h_y,
  input  logic [RATIO_W-1:0]   ratio_v_y,
  input  logic [RATIO_W-1:0]   ratio_h_c,
  input  logic [RATIO_W-1:0]   ratio_v_c,
  input  logic [TAP_W-1:0]     tap_h_y,
  input  logic [TAP_W-1:0]     tap_v_y,
  input  logic [TAP_W-1:0]     tap_h_c,
  input  logic [TAP_W-1:0]     tap_v_c,
  input  logic [DIM_W-1:0]     act_w,
  input  logic [DIM_W-1:0]     act_h,
  input  logic [DIM_W-1:0]     out_x,
  input  logic [DIM_W-1:0]     out_y,
  input  logic [DIM_W-1:0]     out_w,
  input  logic [DIM_W-1:0]     out_h,
  output logic [2:0]           mode,
  output logic [15:0]          blk_y,
  output logic [15:0]          blk_c,
  output logic [4*ENC_W-1:0]   tap_code,
  output logic [DIM_W-1:0]     marg_l,
  output logic [DIM_W-1:0]     marg_r,
  output logic [DIM_W-1:0]     marg_t,
  output logic [DIM_W-1:0]     marg_b,
  output logic                 marg_err,
  output logic                 cfg_illegal,
  output logic                 out_valid
);

  localparam int NUM_AXES = 2;

  // ---------------- mode selection ----------------
  scl_mode_e mode_nx;
  logic      video_nx;

  scl_mode_sel #(
    .RATIO_W(RATIO_W),
    .FRAC_W (FRAC_W)
  ) u_mode_sel (
    .fmt_class  (fmt_class),
    .fixed_cap  (fixed_cap),
    .force_scale(force_scale),
    .ratios     ({ratio_v_c, ratio_h_c, ratio_v_y, ratio_h_y}),
    .mode       (mode_nx),
    .is_video   (video_nx)
  );

  // ---------------- tap encoding ----------------
  logic [3:0][ENC_W-1:0] enc_nx;
  logic                  taps_legal;

  scl_tap_encode #(
    .TAP_W   (TAP_W),
    .MAX_TAPS(MAX_TAPS),
    .NUM_FLD (4),
    .ENC_W   (ENC_W)
  ) u_tap_enc (
    .taps ({tap_v_c, tap_h_c, tap_v_y, tap_h_y}),
    .enc  (enc_nx),
    .legal(taps_legal)
  );

  // ---------------- margins, one per axis ----------------
  logic [NUM_AXES-1:0][DIM_W-1:0] ext_a, org_a, spn_a, far_a;
  logic [NUM_AXES-1:0]            clamp_a;

  assign ext_a = {act_h, act_w};
  assign org_a = {out_y, out_x};
  assign spn_a = {out_h, out_w};

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    scl_margin_calc #(.DIM_W(DIM_W)) u_marg (
      .extent (ext_a[a]),
      .origin (org_a[a]),
      .span   (spn_a[a]),
      .margin (far_a[a]),
      .clamped(clamp_a[a])
    );
  end

  // ---------------- output register stage ----------------
  logic accept;
  assign accept = load & taps_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= MODE_BYP444;
      blk_y       <= BLK_ZERO;
      blk_c       <= BLK_ZERO;
      tap_code    <= '0;
      marg_l      <= '0;
      marg_r      <= '0;
      marg_t      <= '0;
      marg_b      <= '0;
      marg_err    <= 1'b0;
      cfg_illegal <= 1'b0;
      out_valid   <= 1'b0;
    end else begin
      out_valid <= accept;
      if (load)
        cfg_illegal <= ~taps_legal;
      if (accept) begin
        mode     <= mode_nx;
        blk_y    <= BLK_ZERO;
        blk_c    <= video_nx ? BLK_CHROMA_MID : BLK_ZERO;
        tap_code <= enc_nx;
        marg_l   <= out_x;
        marg_t   <= out_y;
        marg_r   <= far_a[0];
        marg_b   <= far_a[1];
        marg_err <= |clamp_a;
      end
    end
  end

endmodule

// File: rtl/scl_mode_decode_chk.sv
module scl_mode_decode_chk #(
  parameter int RATIO_W  = 24,
  parameter int TAP_W    = 4,
  parameter int MAX_TAPS = 8,
  parameter int DIM_W    = 14,
  parameter int ENC_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               load,
  input logic [1:0]         fmt_class,
  input logic [RATIO_W-1:0] ratio_h_y,
  input logic [TAP_W-1:0]   tap_h_y,
  input logic [2:0]         mode,
  input logic [15:0]        blk_y,
  input logic [15:0]        blk_c,
  input logic [4*ENC_W-1:0] tap_code,
  input logic [DIM_W-1:0]   marg_r,
  input logic [DIM_W-1:0]   marg_b,
  input logic               marg_err,
  input logic               cfg_illegal,
  input logic               out_valid
);

  assert_valid_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(load));

  assert_hold_without_load_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> ($stable(mode) && $stable(tap_code) && $stable(blk_c) && !out_valid));

  assert_refused_load_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_illegal && $past(load)) |-> ($stable(mode) && $stable(tap_code) && !out_valid));

  assert_mode_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd6);

  assert_clamp_gives_zero_R8: assert property (@(posedge clk) disable iff (rst)
    marg_err |-> (marg_r == '0 || marg_b == '0));

  assert_luma_black_R5: assert property (@(posedge clk) disable iff (rst)
    blk_y == 16'h0000);

  assert_rgb_chroma_black_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1) |-> (blk_c == 16'h0000));

  assert_yuv_chroma_black_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 || mode == 3'd3 || mode == 3'd4 || mode == 3'd5) |-> (blk_c == 16'h8000));

  assert_not_both_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !(cfg_illegal && out_valid));

endmodule

bind scl_mode_decode scl_mode_decode_chk #(
  .RATIO_W (RATIO_W),
  .TAP_W   (TAP_W),
  .MAX_TAPS(MAX_TAPS),
  .DIM_W   (DIM_W),
  .ENC_W   (ENC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .fmt_class  (fmt_class),
  .ratio_h_y  (ratio_h_y),
  .tap_h_y    (tap_h_y),
  .mode       (mode),
  .blk_y      (blk_y),
  .blk_c      (blk_c),
  .tap_code   (tap_code),
  .marg_r     (marg_r),
  .marg_b     (marg_b),
  .marg_err   (marg_err),
  .cfg_illegal(cfg_illegal),
  .out_valid  (out_valid)
);

// File: tb/scl_mode_decode_bench.sv
module scl_mode_decode_bench;

  localparam int RW = 24;
  localparam int TW = 4;
  localparam int DW = 14;
  localparam int EW = 3;
  localparam logic [RW-1:0] ONE  = 24'h080000;
  localparam logic [RW-1:0] TWO  = 24'h100000;
  localparam logic [RW-1:0] HALF = 24'h040000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [1:0] fmt_class = '0;
  logic fixed_cap = 1'b0, force_scale = 1'b0;
  logic [RW-1:0] ratio_h_y = '0, ratio_v_y = '0, ratio_h_c = '0, ratio_v_c = '0;
  logic [TW-1:0] tap_h_y = 4'd1, tap_v_y = 4'd1, tap_h_c = 4'd1, tap_v_c = 4'd1;
  logic [DW-1:0] act_w = '0, act_h = '0, out_x = '0, out_y = '0, out_w = '0, out_h = '0;
  logic [2:0] mode;
  logic [15:0] blk_y, blk_c;
  logic [4*EW-1:0] tap_code;
  logic [DW-1:0] marg_l, marg_r, marg_t, marg_b;
  logic marg_err, cfg_illegal, out_valid;

  always #5 clk = ~clk;

  scl_mode_decode u_scl_mode_decode (.*);

  typedef struct {
    logic [2:0]      mode;
    logic [15:0]     blk_c;
    logic [4*EW-1:0] taps;
    logic [DW-1:0]   l, r, t, b;
    logic            err;
  } exp_t;

  exp_t exp_q[$];
  exp_t last;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [2:0] ref_mode(input logic [1:0] f, input bit cap, input bit frc,
      input logic [RW-1:0] hy, input logic [RW-1:0] vy, input logic [RW-1:0] hc, input logic [RW-1:0] vc);
    bit ly, lc;
    ly = (hy == ONE) && (vy == ONE);
    lc = (hc == ONE) && (vc == ONE);
    if (cap && f == 2'd3) return 3'd6;
    if (ly && lc && !frc) return 3'd0;
    if (f == 2'd1) return 3'd2;
    if (f != 2'd2) return 3'd1;
    if (ly) return 3'd4;
    if (lc) return 3'd5;
    return 3'd3;
  endfunction

  // monitor: pops an expected item on every valid pulse
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(mode == e.mode, "R1/R2/R3/R4 mode", 32'(mode), 32'(e.mode));
        chk(blk_y == 16'h0 && blk_c == e.blk_c, "R5 black offsets", {blk_y, blk_c}, {16'h0, e.blk_c});
        chk(tap_code == e.taps, "R6 tap codes", 32'(tap_code), 32'(e.taps));
        chk(marg_l == e.l && marg_t == e.t, "R7 left/top margin", {marg_l, marg_t}, {e.l, e.t});
        chk(marg_r == e.r && marg_b == e.b, "R7/R8 right/bottom margin", {marg_r, marg_b}, {e.r, e.b});
        chk(marg_err == e.err, "R8 margin error", 32'(marg_err), 32'(e.err));
        chk(cfg_illegal == 1'b0, "R10 flag clear on legal load", 32'(cfg_illegal), 32'd0);
        last = e;
      end
    end
  end

  task automatic cfg(input logic [1:0] f, input bit cap, input bit frc,
      input logic [RW-1:0] hy, input logic [RW-1:0] vy, input logic [RW-1:0] hc, input logic [RW-1:0] vc,
      input logic [TW-1:0] thy, input logic [TW-1:0] tvy, input logic [TW-1:0] thc, input logic [TW-1:0] tvc,
      input int aw, input int ah, input int ox, input int oy, input int ow, input int oh);
    bit legal;
    exp_t e, prev;
    int rr, bb;
    prev = last;
    @(negedge clk);
    fmt_class = f; fixed_cap = cap; force_scale = frc;
    ratio_h_y = hy; ratio_v_y = vy; ratio_h_c = hc; ratio_v_c = vc;
    tap_h_y = thy; tap_v_y = tvy; tap_h_c = thc; tap_v_c = tvc;
    act_w = DW'(aw); act_h = DW'(ah); out_x = DW'(ox); out_y = DW'(oy); out_w = DW'(ow); out_h = DW'(oh);
    legal = thy >= 1 && thy <= 8 && tvy >= 1 && tvy <= 8 && thc >= 1 && thc <= 8 && tvc >= 1 && tvc <= 8;
    if (legal) begin
      e.mode  = ref_mode(f, cap, frc, hy, vy, hc, vc);
      e.blk_c = (f == 2'd1 || f == 2'd2) ? 16'h8000 : 16'h0000;
      e.taps  = {EW'(tvc - 1), EW'(thc - 1), EW'(tvy - 1), EW'(thy - 1)};
      rr = aw - ox - ow;
      bb = ah - oy - oh;
      e.l = DW'(ox); e.t = DW'(oy);
      e.r = (rr < 0) ? '0 : DW'(rr);
      e.b = (bb < 0) ? '0 : DW'(bb);
      e.err = (rr < 0) || (bb < 0);
      exp_q.push_back(e);
    end
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    if (legal) begin
      chk(out_valid == 1'b1, "R9 valid one cycle after load", 32'(out_valid), 32'd1);
    end else begin
      chk(cfg_illegal == 1'b1, "R10 illegal flag", 32'(cfg_illegal), 32'd1);
      chk(out_valid == 1'b0, "R10 no valid on refused load", 32'(out_valid), 32'd0);
      chk(mode == prev.mode && tap_code == prev.taps, "R10 mode/taps held", {mode, tap_code}, {prev.mode, prev.taps});
      chk(marg_r == prev.r && marg_l == prev.l && blk_c == prev.blk_c, "R10 margins/offset held",
          {marg_r, marg_l}, {prev.r, prev.l});
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid lasts one cycle", 32'(out_valid), 32'd0);
  endtask

  initial begin
    last = '{default: '0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(mode == 3'd0 && tap_code == '0 && blk_c == '0 && blk_y == '0, "R11 reset mode/taps/offsets",
        {mode, tap_code, blk_c}, 32'd0);
    chk(marg_l == '0 && marg_r == '0 && marg_t == '0 && marg_b == '0, "R11 reset margins",
        {marg_l, marg_r}, 32'd0);
    chk(!marg_err && !cfg_illegal && !out_valid, "R11 reset flags",
        {marg_err, cfg_illegal, out_valid}, 32'd0);

    // R1 half-float with fixed capability: full bypass despite unity ratios
    cfg(2'd3, 1, 0, ONE, ONE, ONE, ONE, 4, 4, 2, 2, 1920, 1080, 0, 0, 1920, 1080);
    // R1 half-float without capability, scaled: falls to RGB scaling
    cfg(2'd3, 0, 0, TWO, ONE, ONE, ONE, 4, 4, 4, 4, 1920, 1080, 0, 0, 1920, 1080);
    // R1/R2 half-float without capability, unity: 4:4:4 bypass
    cfg(2'd3, 0, 0, ONE, ONE, ONE, ONE, 2, 2, 2, 2, 800, 600, 10, 20, 700, 500);
    // R2 RGB unity, force set: RGB scaling (R3)
    cfg(2'd0, 0, 1, ONE, ONE, ONE, ONE, 8, 8, 8, 8, 800, 600, 0, 0, 800, 600);
    // R3 YCbCr 4:4:4 scaled
    cfg(2'd1, 1, 0, HALF, HALF, HALF, HALF, 6, 5, 3, 7, 1280, 720, 100, 50, 1000, 600);
    // R4 4:2:0 luma unity, chroma scaled
    cfg(2'd2, 0, 0, ONE, ONE, TWO, TWO, 4, 4, 2, 2, 1280, 720, 0, 0, 1280, 720);
    // R4 4:2:0 all unity with force: luma priority wins
    cfg(2'd2, 0, 1, ONE, ONE, ONE, ONE, 4, 4, 2, 2, 1280, 720, 0, 0, 1280, 720);
    // R4 4:2:0 luma scaled, chroma unity
    cfg(2'd2, 0, 0, HALF, ONE, ONE, ONE, 3, 3, 3, 3, 1280, 720, 0, 0, 1280, 720);
    // R4 4:2:0 only one luma direction unity: chroma half-unity -> full 4:2:0 scaling
    cfg(2'd2, 0, 0, ONE, HALF, ONE, TWO, 5, 6, 7, 8, 1280, 720, 0, 0, 1280, 720);
    // R8 right margin negative, bottom positive
    cfg(2'd0, 0, 0, TWO, TWO, TWO, TWO, 1, 1, 1, 1, 100, 100, 60, 10, 50, 30);
    // R8 bottom margin negative, right exactly zero
    cfg(2'd0, 0, 0, TWO, TWO, TWO, TWO, 2, 2, 2, 2, 100, 100, 40, 90, 60, 20);
    // R6 boundary tap counts 1 and 8 in distinct fields
    cfg(2'd1, 0, 0, TWO, ONE, ONE, ONE, 8, 1, 8, 1, 640, 480, 5, 6, 600, 400);
    // R10 refused: tap 0, with different ratios and geometry
    cfg(2'd2, 1, 1, TWO, TWO, TWO, TWO, 0, 4, 4, 4, 50, 50, 1, 2, 3, 4);
    // R10 refused: tap above limit
    cfg(2'd0, 0, 0, ONE, ONE, ONE, ONE, 4, 4, 9, 4, 300, 300, 7, 7, 7, 7);

    // R9 hold: change inputs without a load
    @(negedge clk);
    fmt_class = 2'd2; ratio_h_y = HALF; tap_h_y = 4'd3; out_x = 14'd33; act_w = 14'd900;
    repeat (3) @(negedge clk);
    chk(mode == last.mode && tap_code == last.taps && marg_l == last.l && marg_r == last.r,
        "R9 outputs hold without load", {mode, tap_code}, {last.mode, last.taps});
    chk(cfg_illegal == 1'b1, "R10 flag held until next load", 32'(cfg_illegal), 32'd1);

    // R10 next legal load clears the flag (checked in monitor)
    cfg(2'd1, 0, 0, ONE, ONE, ONE, ONE, 4, 4, 4, 4, 320, 240, 0, 0, 320, 240);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9 every accepted load produced a valid", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule